// File: doc/BRIEF.md
# Decoded Block Buffer Reader

This block sits between a block decoder and a host controller. The decoder presents each decoded 16-bit data block together with its status fields on a one-cycle write strobe. The block stores these blocks in a 24-entry circular buffer. The host reads them back over a three-wire serial read port made of a chip enable, a serial clock and a serial data output. Each block leaves the port as a 32-bit word that starts with a fixed header. Inside the word the block adds occupancy information, so the host knows how much is still queued.

An active-low request line tells the host that unread blocks are waiting. After every readout the line is held high for a programmable hold-off time. Because of this, a host sharing the line with other devices can tell who asked. A level-sensitive synchronization reset empties the buffer. Blocks that arrive while the decoder is reacquiring lock are kept but hidden. They become readable, oldest first, once lock is reported. A write-unsynchronized enable decides whether blocks that arrive outside lock are kept at all.

The serial port is sampled with the system clock: `rd_ce` and `rd_sclk` are expected to be synchronous and much slower than `clk`.

Top module: `blkbuf_reader`

## Requirements
- R1: The buffer stores up to DEPTH (24) blocks in write order. An accepted write strobe stores the data, the offset-detected flag, the offset code, the special-signal flag, the error count, and the value of `locked` at the time of the write.
- R2: A readout word is sent MSB first, one bit per rising `rd_sclk` edge. Word bit 31 is on `rd_sout` from the second `clk` edge after `rd_ce` rises. The fields, from bit 31 down, are: bits 31:28 = 1010; bit 27 = offset-detected; bits 26:24 = offset code; bit 23 = more-data (1 when at least two readable blocks, the current one included, are stored); bits 22:21 = fill code; bit 20 = special-signal; bit 19 = synchronized-at-write; bits 18:16 = error count; bits 15:0 = data.
- R3: The fill code gives the readable blocks, the current one included: 00 for 1 to 7, 01 for 8 to 15, 10 for 16 to 23, and 11 for 24.
- R4: With no readable block, every word read is all zeros and the read removes nothing.
- R5: When `rd_ce` falls after 1 to 30 bits of a word were clocked out, the next read restarts that same word. When it falls after 31 bits, the word counts as consumed. A word is also consumed when all 32 bits are clocked out.
- R6: A write is dropped when `keep_unsync` is 0, `locked` is 0 and no reacquisition is pending. When `keep_unsync` is 1, it is stored regardless of `locked`.
- R7: `req_n` goes low on the second `clk` edge after an accepted write to an empty, idle buffer. When `rd_ce` falls, `req_n` is high from the next edge for HOLD_CYC edges. It then returns low only if readable blocks remain.
- R8: While `sync_rst` is high, the buffer empties and writes are ignored. After it is released, blocks are stored but hidden (reads give zeros and `req_n` stays high) until `locked` is seen high. Then they become readable, oldest first.
- R9: A write to a full buffer overwrites the oldest entry. The read position moves past it, so the 24 newest blocks remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe presenting a decoded block |
| wr_data | input | 16 | Decoded data block |
| wr_ofs_det | input | 1 | Offset word was detected for this block |
| wr_ofs_code | input | 3 | Offset word code |
| wr_special | input | 1 | Special-signal detected flag |
| wr_err | input | 3 | Corrected-bit count or uncorrectable code |
| locked | input | 1 | Decoder currently synchronized |
| keep_unsync | input | 1 | Also store blocks received outside lock |
| sync_rst | input | 1 | Synchronization reset, level sensitive |
| rd_ce | input | 1 | Read-port chip enable |
| rd_sclk | input | 1 | Read-port serial clock |
| rd_sout | output | 1 | Read-port serial data, MSB first |
| req_n | output | 1 | Active-low read request |

## Verification
Bit 31 of a word is sampled two `clk` edges after the bench raises `rd_ce`. Each later bit is sampled four edges after the previous one, just before the next rising `rd_sclk`. The request line is checked one edge after a write (still high) and two edges after it (low). After a readout it is checked HOLD_CYC edges after the `rd_ce` fall (still high) and one edge later (low, when data remains). After a lock is reported, it is checked two edges later. All of these samples are taken on the falling clock edge. Expected words come from a queue model in the bench. The model applies overwrite, hiding and fill encoding arithmetically. A sweep reads every fill level from 24 down to 1, so every fill code and the more-data flag's fall are covered.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;

    localparam logic [3:0] WORD_HDR = 4'b1010;
    localparam int         WORD_W   = 32;
    localparam int         FILL_MID = 8;
    localparam int         FILL_HI  = 16;

    typedef struct packed {
        logic        ofs_det;
        logic [2:0]  ofs_code;
        logic        special;
        logic        synced;
        logic [2:0]  err;
        logic [15:0] data;
    } blk_entry_t;

    function automatic logic [1:0] fill_code(input logic [7:0] cnt, input logic [7:0] depth);
        if (cnt >= depth)              return 2'b11;
        else if (cnt >= 8'(FILL_HI))   return 2'b10;
        else if (cnt >= 8'(FILL_MID))  return 2'b01;
        else                           return 2'b00;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input blk_entry_t e,
                                                    input logic [7:0] cnt,
                                                    input logic [7:0] depth);
        if (cnt == 8'd0) return '0;
        return {WORD_HDR, e.ofs_det, e.ofs_code, (cnt > 8'd1), fill_code(cnt, depth),
                e.special, e.synced, e.err, e.data};
    endfunction

endpackage

// File: rtl/blkbuf_ring.sv
module blkbuf_ring
    import blkbuf_pkg::*;
#(
    parameter int DEPTH = 24,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  blk_entry_t    push_e,
    input  logic          pop,
    output blk_entry_t    head_e,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [AW-1:0] head;
        logic [AW-1:0] tail;
        logic [CW-1:0] count;
    } ring_st_t;

    ring_st_t   st_d, st_q;
    blk_entry_t mem [DEPTH];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (push) st_d.tail = nxt(st_q.tail);
            if (pop)  st_d.head = nxt(st_q.head);
            if (push && !pop) begin
                if (st_q.count == CW'(DEPTH)) st_d.head  = nxt(st_q.head);
                else                          st_d.count = st_q.count + CW'(1);
            end else if (pop && !push) begin
                st_d.count = st_q.count - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clear) mem[st_q.tail] <= push_e;
    end

    assign head_e = mem[st_q.head];
    assign count  = st_q.count;

    // R1: occupancy never exceeds the capacity
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));

    // R9: a write into a full ring keeps it full and moves the oldest position on
    a_r9_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clear && st_q.count == CW'(DEPTH))
        |=> (st_q.count == CW'(DEPTH) && st_q.head != $past(st_q.head)));

    // R4: nothing is removed from an empty ring
    a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.count != '0);

endmodule

// File: rtl/blkbuf_serial.sv
module blkbuf_serial
    import blkbuf_pkg::*;
#(
    parameter int DEPTH = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       ce,
    input  logic       sclk,
    input  logic [7:0] avail,
    input  blk_entry_t head_e,
    output logic       pop,
    output logic       read_end,
    output logic       sout
);

    localparam int BW = $clog2(WORD_W + 1);
    localparam logic [BW-1:0] LAST_IDX = BW'(WORD_W - 1);

    typedef struct packed {
        logic              ce_q;
        logic              sclk_q;
        logic              loaded;
        logic              has;
        logic [BW-1:0]     bits;
        logic [WORD_W-1:0] shreg;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic    rise;

    always_comb begin
        st_d        = st_q;
        st_d.ce_q   = ce;
        st_d.sclk_q = sclk;
        pop         = 1'b0;
        read_end    = 1'b0;
        rise        = sclk && !st_q.sclk_q;
        if (clear) begin
            st_d.loaded = 1'b0;
            st_d.bits   = '0;
            st_d.shreg  = '0;
        end else if (!ce) begin
            if (st_q.ce_q) begin
                read_end = 1'b1;
                if (st_q.loaded && st_q.has && st_q.bits == LAST_IDX) pop = 1'b1;
            end
            st_d.loaded = 1'b0;
            st_d.bits   = '0;
            st_d.shreg  = '0;
        end else if (!st_q.loaded) begin
            st_d.shreg  = pack_word(head_e, avail, 8'(DEPTH));
            st_d.has    = (avail != 8'd0);
            st_d.loaded = 1'b1;
            st_d.bits   = '0;
        end else if (rise) begin
            if (st_q.bits == LAST_IDX) begin
                pop         = st_q.has;
                st_d.loaded = 1'b0;
                st_d.bits   = '0;
            end else begin
                st_d.shreg = st_q.shreg << 1;
                st_d.bits  = st_q.bits + BW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sout = st_q.loaded ? st_q.shreg[WORD_W-1] : 1'b0;

    // R5: a word is only consumed from a loaded, non-empty snapshot
    a_r5_pop_source: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.loaded && st_q.has));

    // R4: an empty snapshot drives only zeros
    a_r4_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.loaded && !st_q.has) |-> !sout);

    // R2: a freshly loaded non-empty word starts with the fixed header
    a_r2_header: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.loaded && st_q.has && st_q.bits == '0)
        |-> st_q.shreg[WORD_W-1 -: 4] == WORD_HDR);

endmodule

// File: rtl/blkbuf_req.sv
module blkbuf_req #(
    parameter int HOLD_CYC = 66250,
    localparam int HW = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic read_end,
    input  logic pending,
    output logic req_n
);

    typedef struct packed {
        logic [HW-1:0] hold;
        logic          req_n;
    } req_st_t;

    req_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (read_end)             st_d.hold = HW'(HOLD_CYC);
        else if (st_q.hold != '0) st_d.hold = st_q.hold - HW'(1);
        st_d.req_n = (st_d.hold != '0) || !pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold  <= '0;
            st_q.req_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_n = st_q.req_n;

    // R7: the request line is released right after a readout ends
    a_r7_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        read_end |=> req_n);

    // R7: no request while the hold-off window runs
    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold != '0) |-> req_n);

endmodule

// File: rtl/blkbuf_reader.sv
module blkbuf_reader
    import blkbuf_pkg::*;
#(
    parameter int DEPTH    = 24,
    parameter int HOLD_CYC = 66250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  logic [15:0] wr_data,
    input  logic        wr_ofs_det,
    input  logic [2:0]  wr_ofs_code,
    input  logic        wr_special,
    input  logic [2:0]  wr_err,
    input  logic        locked,
    input  logic        keep_unsync,
    input  logic        sync_rst,
    input  logic        rd_ce,
    input  logic        rd_sclk,
    output logic        rd_sout,
    output logic        req_n
);

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic acq;
    } top_st_t;

    top_st_t       st_d, st_q;
    logic          accept;
    logic          visible;
    logic          pop;
    logic          read_end;
    logic [7:0]    avail;
    logic [CW-1:0] count;
    blk_entry_t    new_e;
    blk_entry_t    head_e;

    always_comb begin
        st_d = st_q;
        if (sync_rst)    st_d.acq = 1'b1;
        else if (locked) st_d.acq = 1'b0;
        accept  = wr_stb && !sync_rst && (keep_unsync || locked || st_q.acq);
        visible = !st_q.acq;
        avail   = visible ? 8'(count) : 8'd0;
        new_e.ofs_det  = wr_ofs_det;
        new_e.ofs_code = wr_ofs_code;
        new_e.special  = wr_special;
        new_e.synced   = locked;
        new_e.err      = wr_err;
        new_e.data     = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    blkbuf_ring #(.DEPTH(DEPTH)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (sync_rst),
        .push   (accept),
        .push_e (new_e),
        .pop    (pop),
        .head_e (head_e),
        .count  (count)
    );

    blkbuf_serial #(.DEPTH(DEPTH)) u_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sync_rst),
        .ce       (rd_ce),
        .sclk     (rd_sclk),
        .avail    (avail),
        .head_e   (head_e),
        .pop      (pop),
        .read_end (read_end),
        .sout     (rd_sout)
    );

    blkbuf_req #(.HOLD_CYC(HOLD_CYC)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .read_end (read_end),
        .pending  (avail != 8'd0),
        .req_n    (req_n)
    );

    // R8: a synchronization reset leaves the buffer empty
    a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rst |=> count == '0);

    // R8: no request while reacquisition keeps blocks hidden
    a_r8_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acq && $past(st_q.acq)) |-> req_n);

    // R6: an unlocked write is dropped when unsynchronized storage is off
    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !keep_unsync && !locked && !st_q.acq && !sync_rst && !pop)
        |=> count == $past(count));

endmodule

// File: tb/tb_blkbuf_reader.sv
`timescale 1ns/1ps
module tb_blkbuf_reader;

    localparam int DEPTH = 24;
    localparam int HOLD  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_ofs_det = 1'b0;
    logic [2:0]  wr_ofs_code = '0;
    logic        wr_special = 1'b0;
    logic [2:0]  wr_err = '0;
    logic        locked = 1'b0;
    logic        keep_unsync = 1'b0;
    logic        sync_rst = 1'b0;
    logic        rd_ce = 1'b0;
    logic        rd_sclk = 1'b0;
    logic        rd_sout;
    logic        req_n;

    always #2 clk = ~clk;

    blkbuf_reader #(.DEPTH(DEPTH), .HOLD_CYC(HOLD)) dut (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model: {det, code[2:0], spc, sync, err[2:0], data[15:0]}
    logic [24:0] mq [0:255];
    int  mh = 0, mt = 0, mc = 0;
    bit  m_acq = 1'b0;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] mfill(input int c);
        if (c == 24) return 2'b11;
        if (c >= 16) return 2'b10;
        if (c >= 8)  return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_word();
        int v;
        logic [24:0] e;
        v = m_acq ? 0 : mc;
        if (v == 0) return 32'h0;
        e = mq[mh];
        return {4'b1010, e[24], e[23:21], (v > 1), mfill(v), e[20], e[19], e[18:16], e[15:0]};
    endfunction

    task automatic model_pop();
        if (!m_acq && mc > 0) begin
            mh++;
            mc--;
        end
    endtask

    task automatic write_blk(input logic [15:0] d, input logic [2:0] code, input logic det,
                             input logic spc, input logic [2:0] err);
        wr_data = d; wr_ofs_code = code; wr_ofs_det = det; wr_special = spc; wr_err = err;
        wr_stb = 1'b1;
        if (!sync_rst && (keep_unsync || locked || m_acq)) begin
            mq[mt] = {det, code, spc, locked, err, d};
            mt++;
            if (mc == DEPTH) mh++;
            else mc++;
        end
        step(1);
        wr_stb = 1'b0;
    endtask

    task automatic read_word(input int nbits, output logic [31:0] w);
        w = '0;
        rd_ce = 1'b1;
        step(2);
        for (int i = 0; i < nbits; i++) begin
            w[31-i] = rd_sout;
            rd_sclk = 1'b1;
            step(2);
            rd_sclk = 1'b0;
            step(2);
        end
        rd_ce = 1'b0;
    endtask

    task automatic full_read(input string tag);
        logic [31:0] e, w;
        e = exp_word();
        read_word(32, w);
        check(w, e, tag);
        if (e != 0) model_pop();
        step(HOLD + 3);
    endtask

    task automatic blk(input int k);
        write_blk(16'(k * 16'h0731 + 16'h1234), 3'(k), k[0], k[1], 3'(k + 2));
    endtask

    initial begin
        logic [31:0] w, e;
        step(3);
        rst_n = 1'b1;
        step(1);
        check({31'd0, req_n}, 32'd1, "R7 reset req_n high");
        check({31'd0, rd_sout}, 32'd0, "R2 reset sout low");

        // R4: empty read gives zeros
        full_read("R4 empty word");
        check({31'd0, req_n}, 32'd1, "R4 empty no request");

        // R7 write latency, R1/R2 basic content
        locked = 1'b1;
        blk(1);
        check({31'd0, req_n}, 32'd1, "R7 req one edge after write");
        step(1);
        check({31'd0, req_n}, 32'd0, "R7 req two edges after write");
        blk(2);
        blk(3);
        full_read("R2 word 1 of 3");

        // R7 hold-off with data remaining
        e = exp_word();
        read_word(32, w);
        check(w, e, "R2 word 2 of 3");
        model_pop();
        step(1 + HOLD - 1);
        check({31'd0, req_n}, 32'd1, "R7 held high through hold-off");
        step(1);
        check({31'd0, req_n}, 32'd0, "R7 request returns with data left");
        full_read("R2 word 3 of 3");
        check({31'd0, req_n}, 32'd1, "R7 stays high when drained");

        // R3 sweep every fill level
        for (int k = 0; k < DEPTH; k++) blk(10 + k);
        for (int k = 0; k < DEPTH; k++) full_read("R3 fill sweep");

        // R9 overflow
        for (int k = 0; k < DEPTH + 2; k++) blk(50 + k);
        for (int k = 0; k < DEPTH; k++) full_read("R9 overflow keeps newest");
        full_read("R4 drained after overflow");

        // R5 interrupted reads
        blk(90);
        blk(91);
        e = exp_word();
        read_word(10, w);
        check({w[31:22], 22'd0}, {e[31:22], 22'd0}, "R5 partial bits");
        step(HOLD + 3);
        full_read("R5 restart same word");
        blk(92);
        e = exp_word();
        read_word(31, w);
        check({w[31:1], 1'b0}, {e[31:1], 1'b0}, "R5 31-bit bits");
        model_pop();
        step(HOLD + 3);
        full_read("R5 31 bits consumed");
        full_read("R4 empty after R5");

        // R6 gating
        locked = 1'b0;
        keep_unsync = 1'b0;
        blk(100);
        step(2);
        check({31'd0, req_n}, 32'd1, "R6 dropped write no request");
        full_read("R6 dropped write reads zero");
        keep_unsync = 1'b1;
        blk(101);
        step(2);
        check({31'd0, req_n}, 32'd0, "R6 kept unsynced write requests");
        full_read("R6 kept unsynced word");

        // R8 synchronization reset
        locked = 1'b1;
        keep_unsync = 1'b0;
        blk(110);
        blk(111);
        locked = 1'b0;
        sync_rst = 1'b1;
        blk(112);
        step(1);
        sync_rst = 1'b0;
        mh = mt; mc = 0; m_acq = 1'b1;
        step(2);
        check({31'd0, req_n}, 32'd1, "R8 empty after reset");
        blk(113);
        blk(114);
        blk(115);
        step(2);
        check({31'd0, req_n}, 32'd1, "R8 hidden during reacquisition");
        full_read("R8 hidden reads zero");
        locked = 1'b1;
        step(1);
        m_acq = 1'b0;
        step(1);
        check({31'd0, req_n}, 32'd0, "R8 request after lock");
        full_read("R8 acquisition word 1");
        full_read("R8 acquisition word 2");
        full_read("R8 acquisition word 3");
        full_read("R8 drained");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule